// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block derives a slow clock from a fast one when no single integer ratio gives the wanted rate. It holds two integer dividers, each with its own phase counter and its own repeat counter. In single mode only the first divider runs, so the output is the input divided by its ratio. In dual mode the first divider runs for a programmed number of output periods, then the second divider runs for its own number of periods, and the pattern repeats. The long-run output rate is therefore input × (m1 + m2) / (n1·m1 + n2·m2). A typical use is a precise 32.768 kHz sleep clock taken from a crystal that is not a power-of-two multiple of it.

Software loads the mode bit and four parameter fields through simple register writes. Every field holds its real value minus one. The writes land in staged copies. The running copy is refreshed only where a whole pattern ends, so the output never carries a cut-short period. Besides the divided level, the block gives a one-cycle strobe at each output period start and a flag naming the divider in use.

Top module: `frac_clkdiv`

## Requirements
- R1: While reset is low and in the first cycle after it, the block stands at the start of a first-divider period: div_rise = 1, div_clk = 1, div_sel = 0. Reset also returns every field to 0, which selects single mode with ratio 1.
- R2: In single mode (mode bit 0) every output period lasts exactly n1 input cycles, and div_sel stays 0.
- R3: In dual mode (mode bit 1) the output gives m1 periods of n1 cycles with div_sel = 0, then m2 periods of n2 cycles with div_sel = 1, and this order repeats.
- R4: Writes use cfg_addr 0 = mode (cfg_data bit 0), 1 = n1, 2 = m1, 3 = n2, 4 = m2. Each ratio or count field stores its value minus one, so a field of 0 means 1. Other addresses have no effect.
- R5: Within a period of ratio n ≥ 2, div_clk is high for the first floor(n/2) cycles and low for the rest. With ratio 1, div_clk stays high and a new period starts on every cycle.
- R6: Field writes take effect only at the end of a complete dual pattern (the last second-divider period), or at the next period end in single mode. Periods already under way finish with the old settings.
- R7: div_rise is high for exactly the first cycle of each output period, and div_clk is high whenever div_rise is high.
- R8: In dual mode one full pattern spans n1·m1 + n2·m2 input cycles.
- R9: div_sel shows the divider that owns the current period, and it can be 1 only in dual mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Field write strobe |
| cfg_addr | input | 3 | Field select for a write |
| cfg_data | input | CW (12) | Write data, field value minus one |
| div_clk | output | 1 | Divided output level |
| div_rise | output | 1 | One-cycle strobe at each output period start |
| div_sel | output | 1 | Divider owning the current period (0 first, 1 second) |

## Verification
The bench measures each output period by its length, its high time and its owning divider, and compares these with a queue of expected periods. It covers a ratio of 1, where a design that counted from one instead of zero would give periods one cycle too long or never pulse. It covers odd ratios, where a wrong rounding of the high phase shows as a high time one cycle off, and repeat counts of 1, where an off-by-one in the repeat counter would add or drop a whole period before the switch. It writes a new ratio in the middle of a dual pattern and in the middle of a single period. A design that applied the write at once would give a cut-short period or a mixed pattern that the queue rejects. It also times whole dual patterns against n1·m1 + n2·m2.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   localparam int unsigned FLD_AW = 3;

   typedef enum logic [FLD_AW-1:0] {
      FLD_MODE = 3'd0,
      FLD_N1   = 3'd1,
      FLD_M1   = 3'd2,
      FLD_N2   = 3'd3,
      FLD_M2   = 3'd4
   } fld_e;

   localparam int unsigned LANES = 2;

endpackage

// File: rtl/fcd_cfg_regs.sv
module fcd_cfg_regs
   import fcd_pkg::*;
#(
   parameter int NW = 12,
   parameter int MW = 12,
   parameter int CW = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr,
   input  logic [FLD_AW-1:0]       addr,
   input  logic [CW-1:0]           data,
   input  logic                    load,
   output logic                    act_dual,
   output logic [LANES-1:0][NW-1:0] act_n,
   output logic [LANES-1:0][MW-1:0] act_m
);

   logic                     stg_dual;
   logic [LANES-1:0][NW-1:0] stg_n;
   logic [LANES-1:0][MW-1:0] stg_m;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_dual <= 1'b0;
         act_dual <= 1'b0;
      end else begin
         if (wr && addr == FLD_MODE) stg_dual <= data[0];
         if (load) act_dual <= stg_dual;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane_fields
      localparam logic [FLD_AW-1:0] A_N = FLD_AW'(1 + 2 * i);
      localparam logic [FLD_AW-1:0] A_M = FLD_AW'(2 + 2 * i);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stg_n[i] <= '0;
            stg_m[i] <= '0;
            act_n[i] <= '0;
            act_m[i] <= '0;
         end else begin
            if (wr && addr == A_N) stg_n[i] <= data[NW-1:0];
            if (wr && addr == A_M) stg_m[i] <= data[MW-1:0];
            if (load) begin
               act_n[i] <= stg_n[i];
               act_m[i] <= stg_m[i];
            end
         end
      end
   end

   // R6: the running fields move only on a load from the sequencer
   p_fields_on_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_n != $past(act_n) || act_m != $past(act_m) || act_dual != $past(act_dual))
         |-> $past(load));

endmodule

// File: rtl/fcd_lane.sv
module fcd_lane #(
   parameter int NW = 12,
   parameter int MW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          single,
   input  logic [NW-1:0] n_f,
   input  logic [MW-1:0] m_f,
   output logic          at_start,
   output logic          run_done,
   output logic          hi_out
);

   logic [NW-1:0] phase;
   logic [MW-1:0] rep;
   logic          period_end;
   logic [NW:0]   n_real;
   logic [NW:0]   half;
   logic [NW:0]   hi_len;

   assign period_end = active && (phase == n_f);
   assign run_done   = period_end && (single || rep == m_f);
   assign at_start   = active && (phase == '0);

   assign n_real = {1'b0, n_f} + (NW + 1)'(1);
   assign half   = n_real >> 1;
   assign hi_len = (half == '0) ? (NW + 1)'(1) : half;
   assign hi_out = active && ({1'b0, phase} < hi_len);

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         phase <= '0;
         rep   <= '0;
      end else if (period_end) begin
         phase <= '0;
         rep   <= run_done ? '0 : rep + MW'(1);
      end else begin
         phase <= phase + NW'(1);
      end
   end

   // R2: the phase counter never passes the programmed ratio
   p_phase_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= n_f);

   // R3: the repeat counter never passes the programmed count
   p_rep_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rep <= m_f);

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
   import fcd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dual,
   input  logic [LANES-1:0] done,
   output logic             sel,
   output logic             load
);

   assign load = dual ? (sel && done[1]) : done[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel <= 1'b0;
      end else if (load) begin
         sel <= 1'b0;
      end else if (dual && !sel && done[0]) begin
         sel <= 1'b1;
      end
   end

   // R3: control moves between dividers only when the owning lane finishes its run
   p_switch_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel != $past(sel)) |-> $past(done[0] || done[1]));

endmodule

// File: rtl/frac_clkdiv.sv
module frac_clkdiv
   import fcd_pkg::*;
#(
   parameter int NW = 12,
   parameter int MW = 12,
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [2:0]    cfg_addr,
   input  logic [CW-1:0] cfg_data,
   output logic          div_clk,
   output logic          div_rise,
   output logic          div_sel
);

   if (NW < 1 || MW < 1) begin : g_bad_width
      $error("frac_clkdiv: field widths must be at least 1");
   end
   if (CW < NW || CW < MW) begin : g_bad_data
      $error("frac_clkdiv: data width must cover every field");
   end

   logic                     act_dual;
   logic [LANES-1:0][NW-1:0] act_n;
   logic [LANES-1:0][MW-1:0] act_m;
   logic                     load;
   logic                     sel;
   logic [LANES-1:0]         done;
   logic [LANES-1:0]         start;
   logic [LANES-1:0]         hi;

   fcd_cfg_regs #(.NW(NW), .MW(MW), .CW(CW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (cfg_wr),
      .addr     (cfg_addr),
      .data     (cfg_data),
      .load     (load),
      .act_dual (act_dual),
      .act_n    (act_n),
      .act_m    (act_m)
   );

   fcd_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .dual  (act_dual),
      .done  (done),
      .sel   (sel),
      .load  (load)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      fcd_lane #(.NW(NW), .MW(MW)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .active   (sel == 1'(i)),
         .single   (!act_dual),
         .n_f      (act_n[i]),
         .m_f      (act_m[i]),
         .at_start (start[i]),
         .run_done (done[i]),
         .hi_out   (hi[i])
      );
   end

   assign div_clk  = hi[sel];
   assign div_rise = start[sel];
   assign div_sel  = sel;

   // R7: a period start always shows a high level
   p_rise_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      div_rise |-> div_clk);

   // R9: the second divider owns periods only in dual mode
   p_sel_dual_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      div_sel |-> act_dual);

   // R9: at most one lane reports a period start
   p_one_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(start));

endmodule

// File: tb/frac_clkdiv_bench.sv
`timescale 1ns/1ps
module frac_clkdiv_bench;

   localparam int CW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [CW-1:0] cfg_data = '0;
   logic          div_clk, div_rise, div_sel;

   always #2.5 clk = ~clk;

   frac_clkdiv u_frac_clkdiv (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .div_clk(div_clk), .div_rise(div_rise), .div_sel(div_sel)
   );

   typedef struct {
      int    len;
      int    hi;
      int    sel;
      string req;
   } per_t;

   per_t expq[$];
   int   checks = 0;
   int   fails = 0;
   bit   arm = 0, sync_dual = 0, tracking = 0, have_open = 0, prev_sel = 0;
   int   cur_len, cur_hi, cur_sel;
   bit   done_flag = 0;

   task automatic check(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // monitor: measure periods, pop expectations and compare
   always @(negedge clk) begin
      if (!arm) begin
         tracking  = 0;
         have_open = 0;
      end else if (!tracking) begin
         if (div_rise && (!sync_dual || (!div_sel && prev_sel))) begin
            tracking  = 1;
            have_open = 1;
            cur_len = 1; cur_hi = int'(div_clk); cur_sel = int'(div_sel);
         end
      end else if (div_rise) begin
         if (have_open) begin
            if (expq.size() == 0) begin
               check(0, "R3", "unexpected period len", cur_len, 0);
            end else begin
               per_t e;
               e = expq.pop_front();
               check(cur_len == e.len, e.req, "period length", cur_len, e.len);
               check(cur_hi == e.hi, e.req, "high time", cur_hi, e.hi);
               check(cur_sel == e.sel, e.req, "divider select", cur_sel, e.sel);
            end
         end
         have_open = 1;
         cur_len = 1; cur_hi = int'(div_clk); cur_sel = int'(div_sel);
      end else if (have_open) begin
         cur_len++;
         cur_hi += int'(div_clk);
      end
      prev_sel = div_sel;
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 3'(a); cfg_data = CW'(d);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic push_div(int n, int reps, int sel, string req);
      for (int k = 0; k < reps; k++) begin
         per_t e;
         e.len = n; e.hi = (n == 1) ? 1 : n / 2; e.sel = sel; e.req = req;
         expq.push_back(e);
      end
   endtask

   task automatic start_q(bit dual);
      sync_dual = dual;
      arm = 1;
   endtask

   task automatic finish_q();
      while (expq.size() != 0) @(posedge clk);
      arm = 0;
      @(posedge clk);
   endtask

   task automatic seq_len(int expv, string req);
      bit last;
      int cnt;
      @(negedge clk); last = div_sel;
      forever begin
         @(negedge clk);
         if (div_rise && !div_sel && last) break;
         last = div_sel;
      end
      cnt = 0; last = div_sel;
      forever begin
         @(negedge clk);
         cnt++;
         if (div_rise && !div_sel && last) break;
         last = div_sel;
      end
      check(cnt == expv, req, "pattern length", cnt, expv);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      check(div_rise == 1'b1, "R1", "rise in reset", int'(div_rise), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(div_rise == 1'b1, "R1", "rise after reset", int'(div_rise), 1);
      check(div_clk == 1'b1, "R1", "level after reset", int'(div_clk), 1);
      check(div_sel == 1'b0, "R1", "select after reset", int'(div_sel), 0);

      // R5 and R4: default field 0 gives ratio 1
      push_div(1, 4, 0, "R5");
      start_q(0); finish_q();

      // R2: single mode, ratio 6 (field 5); unused address 7 ignored (R4)
      wr(1, 5);
      wr(7, 1);
      repeat (30) @(posedge clk);
      push_div(6, 3, 0, "R2");
      start_q(0); finish_q();

      // R5: odd ratio 7 gives 3 high cycles
      wr(1, 6);
      repeat (30) @(posedge clk);
      push_div(7, 3, 0, "R5");
      start_q(0); finish_q();

      // R3: dual n1=3 m1=2 n2=4 m2=3
      wr(1, 2); wr(2, 1); wr(3, 3); wr(4, 2); wr(0, 1);
      repeat (100) @(posedge clk);
      for (int s = 0; s < 2; s++) begin
         push_div(3, 2, 0, "R3");
         push_div(4, 3, 1, "R3");
      end
      start_q(1); finish_q();
      seq_len(18, "R8");

      // R4: n1=5 m1=1 n2=1 m2=2, fields 4,0,0,1
      wr(1, 4); wr(2, 0); wr(3, 0); wr(4, 1);
      repeat (100) @(posedge clk);
      for (int s = 0; s < 2; s++) begin
         push_div(5, 1, 0, "R4");
         push_div(1, 2, 1, "R4");
      end
      start_q(1); finish_q();
      seq_len(7, "R8");

      // R6: dual n1=4 m1=2 n2=2 m2=2, n1 becomes 6 mid-pattern
      wr(1, 3); wr(2, 1); wr(3, 1); wr(4, 1);
      repeat (100) @(posedge clk);
      push_div(4, 2, 0, "R6");
      push_div(2, 2, 1, "R6");
      push_div(6, 2, 0, "R6");
      push_div(2, 2, 1, "R6");
      start_q(1);
      while (!tracking) @(posedge clk);
      repeat (2) @(posedge clk);
      wr(1, 5);
      finish_q();

      // R6: single n1=5, becomes 3 mid-period
      wr(0, 0); wr(1, 4);
      repeat (100) @(posedge clk);
      push_div(5, 1, 0, "R6");
      push_div(3, 3, 0, "R6");
      start_q(0);
      while (!tracking) @(posedge clk);
      wr(1, 2);
      finish_q();

      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule